// File: doc/BRIEF.md
# Probabilistic TDMA Slot Selector

This block chooses the slot a station will first transmit in when it joins a slotted TDMA network. After a start command it walks a window of candidate slots, one per clock, beginning at a given slot number and wrapping around the end of a 2250-slot frame. For every candidate it asks an external occupancy table whether the slot is taken. Taken slots are passed over. For a free slot it draws a pseudo-random number from 0 to 100 and accepts the slot when the number does not exceed the current persistence threshold. Otherwise the threshold grows by a fixed step and the walk moves on.

The random source is a 16-bit linear feedback shift register whose seed software loads through a write strobe. The register runs on from one selection to the next and is not reseeded by a start. When the window is used up without an acceptance, the block falls back to the last free slot it saw. If no slot in the window was free it reports failure. The result is announced with a one-cycle done strobe and is held until the next selection completes.

The controller has three states. IDLE waits for start. It goes to PROBE on a start with a non-zero window, or straight to REPORT when the window is zero. PROBE tests one candidate per cycle. It stays in PROBE while the candidate is rejected or taken and window remains. It goes to REPORT on an acceptance or on the last candidate. REPORT raises done for one cycle and always returns to IDLE.

Top module: `tdma_slot_picker`

## Requirements
- R1: After reset `done`, `fail` and `hunting` are 0, `chosen_slot` is 0 and the random register holds 1.
- R2: A pulse on `seed_wr` loads `seed_val` into the random register; a zero seed loads 1 instead. Each step shifts the register left by one and inserts the XOR of bits 15, 13, 12 and 10. The draw for a free candidate is the register value modulo 101, taken before the step that candidate causes.
- R3: A free candidate whose draw is less than or equal to the current threshold is chosen. Its number appears on `chosen_slot` with `fail` = 0 while `done` is 1.
- R4: Each free candidate that is rejected raises the threshold by 10, saturating at 100. From that point every free candidate is accepted.
- R5: The starting threshold is `persist_init`, clamped to 10 when larger.
- R6: A candidate marked taken (`cand_taken` = 1) does not step the random register and does not change the threshold.
- R7: Candidates advance by one per cycle; slot 2249 is followed by slot 0, and `cand_slot` is always below 2250.
- R8: When the window ends without an acceptance, the last free candidate is chosen with `fail` = 0. If no candidate was free, or the window length is 0, `fail` = 1 and `chosen_slot` keeps its previous value.
- R9: `done` is a single-cycle pulse that comes one cycle after the last candidate examined, so a run that examines n candidates raises `done` n+1 cycles after the start edge. `start` is ignored while a selection is running.
- R10: While `hunting` is 1, `cand_slot` presents the candidate under test, and `cand_taken` is sampled for it in that same cycle. The first candidate is `start_slot`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_wr | input | 1 | Load strobe for the random register |
| seed_val | input | 16 | Seed value |
| start | input | 1 | Begin a selection (sampled in IDLE) |
| start_slot | input | 12 | First candidate slot |
| span_len | input | 12 | Number of candidates to examine |
| persist_init | input | 7 | Starting persistence threshold |
| cand_slot | output | 12 | Slot being looked up in the occupancy table |
| cand_taken | input | 1 | Occupancy answer for `cand_slot` (1 = taken) |
| hunting | output | 1 | A selection is in progress |
| done | output | 1 | One-cycle result strobe |
| fail | output | 1 | No free slot was found in the window |
| chosen_slot | output | 12 | Selected slot number |

## Verification
The selection is run against four occupancy patterns: all free, even slots taken, only multiples of three free, and all taken. These separate acceptance on the first free slot, skipping that must not consume draws, fallback to the last free slot, and failure. Seeds, starting slots near the frame end and thresholds above the clamp are varied so that the chosen slot shows whether wrap, clamping and saturation all behave as required. Directed runs cover a zero window, a start pulse during a run, and a batch of seeds with a zero starting threshold, where acceptance must come by the eleventh free candidate.

// File: rtl/tdma_sel_pkg.sv
package tdma_sel_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PROBE  = 2'd1,
        ST_REPORT = 2'd2
    } sel_state_e;
endpackage

// File: rtl/tdma_sel_lfsr.sv
module tdma_sel_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] TAPS = 16'hB400
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] state
);
    logic [W-1:0] state_q;
    logic         fb;

    assign fb = ^(state_q & TAPS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= W'(1);
        end else if (load) begin
            state_q <= (load_val == '0) ? W'(1) : load_val;
        end else if (step) begin
            state_q <= {state_q[W-2:0], fb};
        end
    end

    assign state = state_q;
endmodule

// File: rtl/tdma_sel_draw.sv
module tdma_sel_draw #(
    parameter int RW       = 16,
    parameter int PROB_MAX = 100,
    parameter int PROB_W   = 7
) (
    input  logic [RW-1:0]     rnd,
    input  logic [PROB_W-1:0] thr,
    output logic [PROB_W-1:0] draw,
    output logic              accept
);
    always_comb begin
        draw   = PROB_W'(int'(rnd) % (PROB_MAX + 1));
        accept = (draw <= thr);
    end
endmodule

// File: rtl/tdma_slot_wrap.sv
module tdma_slot_wrap #(
    parameter int NUM_SLOTS = 2250,
    parameter int SLOT_W    = 12
) (
    input  logic [SLOT_W-1:0] cur,
    output logic [SLOT_W-1:0] nxt
);
    always_comb begin
        if (cur >= SLOT_W'(NUM_SLOTS - 1)) nxt = '0;
        else                               nxt = cur + SLOT_W'(1);
    end
endmodule

// File: rtl/tdma_slot_picker.sv
module tdma_slot_picker
    import tdma_sel_pkg::*;
#(
    parameter int NUM_SLOTS    = 2250,
    parameter int LFSR_W       = 16,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
    parameter int PROB_MAX     = 100,
    parameter int THR_INIT_MAX = 10,
    parameter int THR_STEP     = 10,
    localparam int SLOT_W      = $clog2(NUM_SLOTS),
    localparam int PROB_W      = $clog2(PROB_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed_wr,
    input  logic [LFSR_W-1:0] seed_val,
    input  logic              start,
    input  logic [SLOT_W-1:0] start_slot,
    input  logic [SLOT_W-1:0] span_len,
    input  logic [PROB_W-1:0] persist_init,
    output logic [SLOT_W-1:0] cand_slot,
    input  logic              cand_taken,
    output logic              hunting,
    output logic              done,
    output logic              fail,
    output logic [SLOT_W-1:0] chosen_slot
);
    sel_state_e        state_q, state_d;
    logic [SLOT_W-1:0] cur_q, left_q, last_free_q, chosen_q, next_slot;
    logic [PROB_W-1:0] thr_q, thr_start, thr_bumped, draw;
    logic              seen_free_q, fail_q;
    logic              probing, is_free, take_it, final_cand;
    logic [LFSR_W-1:0] rnd;

    assign probing    = (state_q == ST_PROBE);
    assign is_free    = probing && !cand_taken;
    assign final_cand = (left_q == SLOT_W'(1));

    tdma_sel_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .load(seed_wr), .load_val(seed_val),
        .step(is_free), .state(rnd)
    );

    tdma_sel_draw #(.RW(LFSR_W), .PROB_MAX(PROB_MAX), .PROB_W(PROB_W)) u_draw (
        .rnd(rnd), .thr(thr_q), .draw(draw), .accept(take_it)
    );

    tdma_slot_wrap #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_wrap (
        .cur(cur_q), .nxt(next_slot)
    );

    always_comb begin
        thr_start = (int'(persist_init) > THR_INIT_MAX) ? PROB_W'(THR_INIT_MAX) : persist_init;
        if (int'(thr_q) + THR_STEP >= PROB_MAX) thr_bumped = PROB_W'(PROB_MAX);
        else                                   thr_bumped = thr_q + PROB_W'(THR_STEP);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = (span_len == '0) ? ST_REPORT : ST_PROBE;
            end
            ST_PROBE: begin
                if ((is_free && take_it) || final_cand) state_d = ST_REPORT;
            end
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // candidate walk and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q       <= '0;
            left_q      <= '0;
            thr_q       <= '0;
            last_free_q <= '0;
            seen_free_q <= 1'b0;
            chosen_q    <= '0;
            fail_q      <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                cur_q       <= (start_slot >= SLOT_W'(NUM_SLOTS)) ? start_slot - SLOT_W'(NUM_SLOTS) : start_slot;
                left_q      <= span_len;
                thr_q       <= thr_start;
                seen_free_q <= 1'b0;
                if (span_len == '0) fail_q <= 1'b1;
            end else if (probing) begin
                cur_q  <= next_slot;
                left_q <= left_q - SLOT_W'(1);
                if (is_free) begin
                    last_free_q <= cur_q;
                    seen_free_q <= 1'b1;
                    if (!take_it) thr_q <= thr_bumped;
                end
                if (is_free && take_it) begin
                    chosen_q <= cur_q;
                    fail_q   <= 1'b0;
                end else if (final_cand) begin
                    if (is_free) begin
                        chosen_q <= cur_q;
                        fail_q   <= 1'b0;
                    end else if (seen_free_q) begin
                        chosen_q <= last_free_q;
                        fail_q   <= 1'b0;
                    end else begin
                        fail_q   <= 1'b1;
                    end
                end
            end
        end
    end

    // outputs
    always_comb begin
        hunting     = probing;
        done        = (state_q == ST_REPORT);
        cand_slot   = cur_q;
        chosen_slot = chosen_q;
        fail        = fail_q;
    end
endmodule

// File: rtl/tdma_slot_picker_chk.sv
module tdma_slot_picker_chk #(
    parameter int NUM_SLOTS = 2250,
    parameter int SLOT_W    = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              hunting,
    input logic              done,
    input logic              fail,
    input logic [SLOT_W-1:0] cand_slot,
    input logic [SLOT_W-1:0] chosen_slot
);
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(hunting) || $past(start)));

    a_r7_cand_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        hunting |-> (cand_slot < SLOT_W'(NUM_SLOTS)));

    a_r7_cand_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (hunting && $past(hunting)) |->
            (cand_slot == (($past(cand_slot) == SLOT_W'(NUM_SLOTS - 1)) ? '0 : $past(cand_slot) + SLOT_W'(1))));

    a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(chosen_slot) && $stable(fail)));

    a_r9_no_done_while_hunting: assert property (@(posedge clk) disable iff (!rst_n)
        hunting |-> !done);
endmodule

bind tdma_slot_picker tdma_slot_picker_chk #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .hunting(hunting), .done(done),
    .fail(fail), .cand_slot(cand_slot), .chosen_slot(chosen_slot)
);

// File: tb/tdma_slot_picker_tb_top.sv
module tdma_slot_picker_tb_top;
    localparam int N = 2250;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seed_wr = 1'b0;
    logic [15:0] seed_val = '0;
    logic        start = 1'b0;
    logic [11:0] start_slot = '0;
    logic [11:0] span_len = '0;
    logic [6:0]  persist_init = '0;
    logic [11:0] cand_slot;
    logic        cand_taken;
    logic        hunting, done, fail;
    logic [11:0] chosen_slot;

    logic occ_tbl [0:N-1];
    assign cand_taken = occ_tbl[cand_slot];

    always #4 clk = ~clk;

    tdma_slot_picker dut_i (
        .clk(clk), .rst_n(rst_n), .seed_wr(seed_wr), .seed_val(seed_val),
        .start(start), .start_slot(start_slot), .span_len(span_len),
        .persist_init(persist_init), .cand_slot(cand_slot), .cand_taken(cand_taken),
        .hunting(hunting), .done(done), .fail(fail), .chosen_slot(chosen_slot)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] m_lfsr;
    int exp_sel, exp_fail, exp_probes;

    typedef struct packed {
        logic [15:0] seed;
        logic [11:0] first;
        logic [11:0] span;
        logic [6:0]  thr;
        logic [1:0]  pat;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{16'hACE1, 12'd0,    12'd20, 7'd10, 2'd0},
        '{16'h1234, 12'd100,  12'd30, 7'd0,  2'd1},
        '{16'hBEEF, 12'd2240, 12'd25, 7'd5,  2'd3},
        '{16'h0000, 12'd500,  12'd15, 7'd10, 2'd0},
        '{16'h7777, 12'd10,   12'd8,  7'd3,  2'd2},
        '{16'h0F0F, 12'd1000, 12'd3,  7'd0,  2'd0},
        '{16'hFFFF, 12'd2249, 12'd12, 7'd60, 2'd1},
        '{16'h5A5A, 12'd40,   12'd40, 7'd10, 2'd3}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] lfsr_next(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    // pattern 0: all free, 1: even slots taken, 2: all taken, 3: free only at multiples of 3
    task automatic fill(input int pat);
        for (int i = 0; i < N; i++) begin
            case (pat)
                0:       occ_tbl[i] = 1'b0;
                1:       occ_tbl[i] = (i % 2 == 0);
                2:       occ_tbl[i] = 1'b1;
                default: occ_tbl[i] = (i % 3 != 0);
            endcase
        end
    endtask

    task automatic model(input int first, input int span, input int thr_in);
        int thr, cur, last, d;
        bit seen, acc;
        thr = (thr_in > 10) ? 10 : thr_in;
        cur = first; seen = 0; acc = 0; last = 0;
        exp_probes = 0;
        for (int i = 0; i < span && !acc; i++) begin
            exp_probes++;
            if (!occ_tbl[cur]) begin
                d = int'(m_lfsr) % 101;
                m_lfsr = lfsr_next(m_lfsr);
                last = cur; seen = 1;
                if (d <= thr) begin
                    acc = 1; exp_sel = cur; exp_fail = 0;
                end else begin
                    thr = (thr + 10 > 100) ? 100 : thr + 10;
                end
            end
            cur = (cur == N - 1) ? 0 : cur + 1;
        end
        if (!acc) begin
            if (seen) begin exp_sel = last; exp_fail = 0; end
            else      exp_fail = 1;
        end
    endtask

    task automatic load_seed(input logic [15:0] s);
        @(negedge clk);
        seed_wr = 1'b1; seed_val = s;
        @(negedge clk);
        seed_wr = 1'b0;
        m_lfsr = (s == 16'h0) ? 16'h1 : s;
    endtask

    task automatic run(input int first, input int span, input int thr_in, input bit poke, input string tag);
        int lat;
        model(first, span, thr_in);
        @(negedge clk);
        start = 1'b1; start_slot = 12'(first); span_len = 12'(span); persist_init = 7'(thr_in);
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        if (span > 0) begin
            chk(hunting === 1'b1, {"R10 hunting ", tag}, int'(hunting), 1);
            chk(cand_slot == 12'(first), {"R10 first candidate ", tag}, int'(cand_slot), first);
        end
        while (done !== 1'b1 && lat < 5000) begin
            @(negedge clk);
            lat++;
            if (poke && lat == 2 && done !== 1'b1) begin
                start = 1'b1; start_slot = 12'd7; span_len = 12'd1; persist_init = 7'd10;
                @(negedge clk);
                start = 1'b0;
                lat++;
            end
        end
        chk(lat == exp_probes + 1, {"R9 latency ", tag}, lat, exp_probes + 1);
        chk(fail == 1'(exp_fail), {"R8 fail flag ", tag}, int'(fail), exp_fail);
        chk(int'(chosen_slot) == exp_sel, {"R3 chosen slot ", tag}, int'(chosen_slot), exp_sel);
        @(negedge clk);
        chk(done === 1'b0, {"R9 done pulse ", tag}, int'(done), 0);
        chk(hunting === 1'b0, {"R9 idle after ", tag}, int'(hunting), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        exp_sel = 0; exp_fail = 0;
        m_lfsr = 16'h1;
        fill(0);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(done === 1'b0,      "R1 done", int'(done), 0);
        chk(fail === 1'b0,      "R1 fail", int'(fail), 0);
        chk(hunting === 1'b0,   "R1 hunting", int'(hunting), 0);
        chk(chosen_slot === '0, "R1 chosen", int'(chosen_slot), 0);
        rst_n = 1'b1;

        // R1 R2: reset value of the random register used without a seed write
        run(300, 10, 2, 1'b0, "unseeded");

        // table walk: R2 R3 R4 R5 R6 R7 R8
        foreach (VECS[k]) begin
            fill(int'(VECS[k].pat));
            load_seed(VECS[k].seed);
            run(int'(VECS[k].first), int'(VECS[k].span), int'(VECS[k].thr), 1'b0, $sformatf("vec%0d", k));
        end

        // R8: zero-length window fails and keeps previous slot
        fill(0);
        run(5, 0, 10, 1'b0, "zero span");

        // R7: wrap, only slot 1 free near frame end
        fill(2);
        occ_tbl[1] = 1'b0;
        load_seed(16'h2468);
        run(2248, 4, 0, 1'b0, "wrap");
        chk(chosen_slot == 12'd1, "R7 wrapped slot", int'(chosen_slot), 1);

        // R9: start during a run is ignored
        fill(1);
        load_seed(16'h1357);
        run(201, 40, 0, 1'b1, "start ignored");

        // R4: saturation forces acceptance by the 11th free candidate
        fill(0);
        for (int s = 1; s <= 12; s++) begin
            load_seed(16'(s * 4099));
            run(700, 30, 0, 1'b0, $sformatf("sat%0d", s));
            chk(exp_probes <= 11, "R4 saturation bound", int'(chosen_slot) - 700 + 1, 11);
        end

        // R6: taken slots never draw; all-taken run then all-free must match model stream
        fill(2);
        load_seed(16'hC0DE);
        run(50, 20, 10, 1'b0, "taken only");
        fill(0);
        run(50, 20, 10, 1'b0, "R6 after taken");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule